// File: doc/BRIEF.md
# Floating-Point Register Stack Control Unit

This block keeps the control state of an eight-entry floating-point register stack: a 3-bit stack top pointer, a translation-mode flag and an 8-bit tag word with one bit per physical register. One command per cycle arrives on `cmdOp`. A command can read or load the top pointer, step it up or down with modulo-8 wrap, switch translation mode on or off, or apply a guarded update to one tag bit. Each command takes effect at the clock edge where it is presented.

A separate combinational path turns a logical register index into a physical index. When translation mode is on, the logical index is offset by the current top pointer modulo 8. When it is off, the index passes through unchanged. A tag update names a bit and an operation code. Only a set from 0 or a clear from 1 is allowed. Any other request leaves the tag word as it was and produces a one-cycle exception pulse.

Top module: `fpstack_ctl`

## Requirements
- R1: After reset, the top pointer is 0, translation mode is off, `tagWord` is all zeros, `excPulse` is 0 and `rdData` is 0. `cmdOp` = 0 is a no-op.
- R2: A read command (`cmdOp` = 1) loads `rdData` with the top pointer zero-extended, one cycle later. `rdData` holds its value until the next read.
- R3: A load command (`cmdOp` = 2) sets the top pointer to `cmdImm`.
- R4: An increment command (`cmdOp` = 3) adds 1 to the top pointer, and 7 wraps to 0.
- R5: A decrement command (`cmdOp` = 4) subtracts 1 from the top pointer, and 0 wraps to 7.
- R6: A set-mode command (`cmdOp` = 5) turns translation mode on. While it is on, `physIdx` = (`logIdx` + top) mod 8, combinationally.
- R7: A clear-mode command (`cmdOp` = 6) turns translation mode off. While it is off, `physIdx` = `logIdx`.
- R8: A tag command (`cmdOp` = 7) uses `tagOp` mod 8 as its operation. Operation 0 changes `tagWord[tagSel]` from 0 to 1. Operation 1 changes it from 1 to 0. All other bits keep their values.
- R9: A tag command that is not allowed leaves `tagWord` unchanged and raises `excPulse` for exactly the next cycle. Not allowed means operation 0 on a bit that is already 1, operation 1 on a bit that is already 0, or operations 2 to 7.
- R10: `excPulse` is 0 in every cycle that does not follow a disallowed tag command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdOp | input | 3 | Command code |
| cmdImm | input | 3 | Immediate value for the load command |
| tagSel | input | 3 | Tag bit selected by a tag command |
| tagOp | input | 5 | Tag operation field (used modulo 8) |
| logIdx | input | 3 | Logical register index |
| physIdx | output | 3 | Physical register index |
| rdData | output | 64 | Top pointer captured by the last read |
| excPulse | output | 1 | One-cycle pulse after a disallowed tag update |
| tagWord | output | 8 | Current tag word |

## Verification
The top pointer has no port of its own. A wrong pointer therefore shows up in two places: on `physIdx` in the same cycle, whenever translation mode is on, and in `rdData` one cycle after a read. The bench issues reads often and drives a random `logIdx` on every command, so a pointer or mode error is seen within a few commands. A wrong tag decision shows up one cycle later, either as a changed `tagWord` or as a wrong `excPulse`, and the bench compares both after every command.

// File: rtl/fpstack_pkg.sv
package fpstack_pkg;

  typedef enum logic [2:0] {
    CMD_NOP   = 3'd0,
    CMD_RDTOP = 3'd1,
    CMD_WRTOP = 3'd2,
    CMD_INC   = 3'd3,
    CMD_DEC   = 3'd4,
    CMD_SETTM = 3'd5,
    CMD_CLRTM = 3'd6,
    CMD_TAG   = 3'd7
  } cmd_e;

  // strobes from control to datapath
  typedef struct packed {
    logic rdTop;
    logic ldTop;
    logic incTop;
    logic decTop;
    logic setTm;
    logic clrTm;
    logic tagWr;
    logic tagVal;
    logic tagErr;
  } strobe_t;

endpackage

// File: rtl/fpstack_ctrl.sv
module fpstack_ctrl
  import fpstack_pkg::*;
#(
  parameter int TAG_OP_W = 5
) (
  input  logic [2:0]          cmdOp,
  input  logic [TAG_OP_W-1:0] tagOp,
  input  logic                selBit,
  output strobe_t             stb
);

  cmd_e cmd;
  logic [2:0] opMod;

  assign cmd   = cmd_e'(cmdOp);
  assign opMod = tagOp[2:0];

  always_comb begin
    stb = '0;
    unique case (cmd)
      CMD_RDTOP: stb.rdTop  = 1'b1;
      CMD_WRTOP: stb.ldTop  = 1'b1;
      CMD_INC:   stb.incTop = 1'b1;
      CMD_DEC:   stb.decTop = 1'b1;
      CMD_SETTM: stb.setTm  = 1'b1;
      CMD_CLRTM: stb.clrTm  = 1'b1;
      CMD_TAG: begin
        if (opMod == 3'd0 && !selBit) begin
          stb.tagWr  = 1'b1;
          stb.tagVal = 1'b1;
        end else if (opMod == 3'd1 && selBit) begin
          stb.tagWr  = 1'b1;
          stb.tagVal = 1'b0;
        end else begin
          stb.tagErr = 1'b1;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/fpstack_dp.sv
module fpstack_dp
  import fpstack_pkg::*;
#(
  parameter int IDX_W  = 3,
  parameter int DATA_W = 64
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 stb,
  input  logic [IDX_W-1:0]        cmdImm,
  input  logic [IDX_W-1:0]        tagSel,
  input  logic [IDX_W-1:0]        logIdx,
  output logic [IDX_W-1:0]        physIdx,
  output logic [IDX_W-1:0]        topQ,
  output logic                    tmQ,
  output logic [(1<<IDX_W)-1:0]   tagWord,
  output logic                    selBit,
  output logic [DATA_W-1:0]       rdData,
  output logic                    excPulse
);

  localparam int NREG = 1 << IDX_W;
  localparam logic [IDX_W-1:0] ONE = IDX_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      topQ <= '0;
    end else if (stb.ldTop) begin
      topQ <= cmdImm;
    end else if (stb.incTop) begin
      topQ <= topQ + ONE;
    end else if (stb.decTop) begin
      topQ <= topQ - ONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmQ <= 1'b0;
    end else if (stb.setTm) begin
      tmQ <= 1'b1;
    end else if (stb.clrTm) begin
      tmQ <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData   <= '0;
      excPulse <= 1'b0;
    end else begin
      excPulse <= stb.tagErr;
      if (stb.rdTop) rdData <= DATA_W'(topQ);
    end
  end

  for (genvar i = 0; i < NREG; i++) begin : g_tag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        tagWord[i] <= 1'b0;
      end else if (stb.tagWr && tagSel == IDX_W'(i)) begin
        tagWord[i] <= stb.tagVal;
      end
    end
  end

  assign selBit  = tagWord[tagSel];
  assign physIdx = tmQ ? logIdx + topQ : logIdx;

endmodule

// File: rtl/fpstack_ctl.sv
module fpstack_ctl
  import fpstack_pkg::*;
#(
  parameter int IDX_W    = 3,
  parameter int DATA_W   = 64,
  parameter int TAG_OP_W = 5
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [2:0]            cmdOp,
  input  logic [IDX_W-1:0]      cmdImm,
  input  logic [IDX_W-1:0]      tagSel,
  input  logic [TAG_OP_W-1:0]   tagOp,
  input  logic [IDX_W-1:0]      logIdx,
  output logic [IDX_W-1:0]      physIdx,
  output logic [DATA_W-1:0]     rdData,
  output logic                  excPulse,
  output logic [(1<<IDX_W)-1:0] tagWord
);

  strobe_t          stb;
  logic             selBit;
  logic [IDX_W-1:0] topQ;
  logic             tmQ;

  fpstack_ctrl #(.TAG_OP_W(TAG_OP_W)) ctrl_i (
    .cmdOp (cmdOp),
    .tagOp (tagOp),
    .selBit(selBit),
    .stb   (stb)
  );

  fpstack_dp #(.IDX_W(IDX_W), .DATA_W(DATA_W)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .cmdImm  (cmdImm),
    .tagSel  (tagSel),
    .logIdx  (logIdx),
    .physIdx (physIdx),
    .topQ    (topQ),
    .tmQ     (tmQ),
    .tagWord (tagWord),
    .selBit  (selBit),
    .rdData  (rdData),
    .excPulse(excPulse)
  );

endmodule

// File: rtl/fpstack_chk.sv
module fpstack_chk #(
  parameter int IDX_W = 3
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [2:0]            cmdOp,
  input logic [IDX_W-1:0]      cmdImm,
  input logic [IDX_W-1:0]      logIdx,
  input logic [IDX_W-1:0]      physIdx,
  input logic [IDX_W-1:0]      topQ,
  input logic [(1<<IDX_W)-1:0] tagWord,
  input logic                  excPulse
);

  // R3
  load_top_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdOp == 3'd2 |=> topQ == $past(cmdImm));

  // R4
  inc_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdOp == 3'd3 |=> topQ == IDX_W'($past(topQ) + 1'b1));

  // R5
  dec_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdOp == 3'd4 |=> topQ == IDX_W'($past(topQ) - 1'b1));

  // R7
  clear_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdOp == 3'd6 |=> physIdx == logIdx);

  // R9
  exc_keeps_tag_chk: assert property (@(posedge clk) disable iff (!rstN)
    excPulse |-> $stable(tagWord));

  // R8
  tag_one_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdOp != 3'd7 |=> $stable(tagWord));

  // R10
  exc_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdOp != 3'd7 |=> !excPulse);

endmodule

bind fpstack_ctl fpstack_chk #(.IDX_W(IDX_W)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .cmdOp   (cmdOp),
  .cmdImm  (cmdImm),
  .logIdx  (logIdx),
  .physIdx (physIdx),
  .topQ    (topQ),
  .tagWord (tagWord),
  .excPulse(excPulse)
);

// File: tb/fpstack_ctl_tb.sv
module fpstack_ctl_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  cmdOp = '0;
  logic [2:0]  cmdImm = '0;
  logic [2:0]  tagSel = '0;
  logic [4:0]  tagOp = '0;
  logic [2:0]  logIdx = '0;
  logic [2:0]  physIdx;
  logic [63:0] rdData;
  logic        excPulse;
  logic [7:0]  tagWord;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [2:0]  mTop = '0;
  logic        mTm = 1'b0;
  logic [7:0]  mTag = '0;
  logic [63:0] mRd = '0;
  logic        mExc = 1'b0;
  string       lastReq = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  fpstack_ctl dut_i (
    .clk(clk), .rstN(rstN), .cmdOp(cmdOp), .cmdImm(cmdImm), .tagSel(tagSel),
    .tagOp(tagOp), .logIdx(logIdx), .physIdx(physIdx), .rdData(rdData),
    .excPulse(excPulse), .tagWord(tagWord)
  );

  function automatic logic [2:0] expPhys(logic tm, logic [2:0] top, logic [2:0] li);
    return tm ? 3'(li + top) : li;
  endfunction

  function automatic logic tagAllowed(logic [4:0] op, logic bitNow);
    return (op[2:0] == 3'd0 && !bitNow) || (op[2:0] == 3'd1 && bitNow);
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic checkState();
    check(rdData == mRd, (lastReq == "R1") ? "R1" : "R2", rdData, mRd);
    check(excPulse == mExc, mExc ? "R9" : "R10", 64'(excPulse), 64'(mExc));
    check(tagWord == mTag, (lastReq == "R9") ? "R9" : "R8", 64'(tagWord), 64'(mTag));
  endtask

  task automatic step(logic [2:0] op, logic [2:0] imm, logic [2:0] sel, logic [4:0] top5, logic [2:0] li);
    logic [2:0]  nTop;
    logic        nTm;
    logic [7:0]  nTag;
    logic [63:0] nRd;
    logic        nExc;
    @(negedge clk);
    checkState();
    cmdOp = op; cmdImm = imm; tagSel = sel; tagOp = top5; logIdx = li;
    #1;
    check(physIdx == expPhys(mTm, mTop, li), mTm ? "R6" : "R7",
          64'(physIdx), 64'(expPhys(mTm, mTop, li)));
    nTop = mTop; nTm = mTm; nTag = mTag; nRd = mRd; nExc = 1'b0;
    lastReq = "R8";
    case (op)
      3'd1: nRd = 64'(mTop);
      3'd2: nTop = imm;
      3'd3: nTop = 3'(mTop + 3'd1);
      3'd4: nTop = 3'(mTop - 3'd1);
      3'd5: nTm = 1'b1;
      3'd6: nTm = 1'b0;
      3'd7: begin
        if (tagAllowed(top5, mTag[sel])) nTag[sel] = ~mTag[sel];
        else begin nExc = 1'b1; lastReq = "R9"; end
      end
      default: ;
    endcase
    @(posedge clk);
    mTop = nTop; mTm = nTm; mTag = nTag; mRd = nRd; mExc = nExc;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    #(CLK_PERIOD * 3);
    // R1 reset state
    @(negedge clk);
    check(rdData == 0, "R1", rdData, 0);
    check(excPulse == 0, "R1", 64'(excPulse), 0);
    check(tagWord == 0, "R1", 64'(tagWord), 0);
    logIdx = 3'd5; #1;
    check(physIdx == 3'd5, "R1", 64'(physIdx), 5);
    rstN = 1'b1;
    // R3 R4: load 7, increment wraps to 0, read
    step(3'd2, 3'd7, 0, 0, 0);
    step(3'd1, 0, 0, 0, 1);
    step(3'd3, 0, 0, 0, 2);
    step(3'd1, 0, 0, 0, 3);
    // R5: decrement from 0 wraps to 7
    step(3'd4, 0, 0, 0, 4);
    step(3'd1, 0, 0, 0, 4);
    // R6: load 5, set mode, index 4 maps to 1
    step(3'd2, 3'd5, 0, 0, 0);
    step(3'd5, 0, 0, 0, 0);
    step(3'd0, 0, 0, 0, 3'd4);
    // R7: clear mode
    step(3'd6, 0, 0, 0, 3'd4);
    step(3'd0, 0, 0, 0, 3'd4);
    // R8: set bit 3, op 8 acts as op 0 on bit 6, clear bit 3
    step(3'd7, 0, 3'd3, 5'd0, 0);
    step(3'd7, 0, 3'd6, 5'd8, 0);
    step(3'd7, 0, 3'd3, 5'd1, 0);
    // R9: op0 on set bit, op1 on clear bit, ops 2..7
    step(3'd7, 0, 3'd6, 5'd0, 0);
    step(3'd7, 0, 3'd2, 5'd1, 0);
    for (int k = 2; k < 8; k++) step(3'd7, 0, 3'(k), 5'(k), 0);
    // R10: no pulse after other commands
    step(3'd0, 0, 0, 0, 0);
    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [2:0] op;
      op = 3'($urandom_range(0, 7));
      step(op, 3'($urandom), 3'($urandom), 5'($urandom_range(0, 3) == 0 ? $urandom : $urandom_range(0, 1)),
           3'($urandom));
    end
    @(negedge clk);
    checkState();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule